// File: doc/BRIEF.md
# PCM Clock-Mode Controller

This block sits beside a PCM serial port and turns a 3-bit speed-select input into the timing that the rest of the port needs. The select code gives the divide ratio that derives a 512 kHz codec enable from the block's own clock, and whether the port runs synchronously or asynchronously. In synchronous modes the supplied bit clock is itself the block clock. In the two low-rate asynchronous modes the block clock is a 4.096 MHz master clock. The slow bit clock and strobe then arrive unrelated to it and are resynchronized before use.

In asynchronous modes the block brings both serial inputs through a two-stage synchronizer and reports single-cycle edge strobes: rising and falling bit-clock edges and a frame-start pulse on the strobe's rising edge. It also raises a one-frame-delay control once the first frame has started, so that the serial datapath can insert its frame of latency. The two unused select codes are flagged as an error and stop the codec enable.

Top module: `pcm_clkmode_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tick_512k, async_mode, sel_err, bclk_rise, bclk_fall, frame_start and frame_delay are all 0.
- R2: Select codes 000, 001, 010 and 011 (bit rates 512, 1536, 2048 and 4096 kHz, block clock equal to the bit clock) give async_mode = 0 and sel_err = 0, one clock after the code is sampled. In steady state tick_512k pulses once every 1, 3, 4 and 8 clocks respectively.
- R3: Select codes 100 (128 kHz) and 101 (256 kHz) with a 4096 kHz block clock give async_mode = 1 and sel_err = 0, one clock after the code is sampled. In steady state tick_512k pulses once every 8 clocks.
- R4: Select codes 110 and 111 give sel_err = 1 and async_mode = 0 one clock after sampling. tick_512k stays 0 while they are held.
- R5: For any divide ratio above 1, tick_512k is a single-cycle pulse. For ratio 1 it is high every clock in steady state.
- R6: In asynchronous mode, a rising or falling bit-clock transition first sampled at clock edge k gives a one-cycle high on bclk_rise or bclk_fall respectively, from edge k+1 to edge k+2. The other edge output stays 0.
- R7: In asynchronous mode, a rising strobe transition first sampled at edge k gives a one-cycle frame_start pulse from edge k+1 to k+2. A falling strobe transition gives no frame_start.
- R8: While async_mode = 0, bclk_rise, bclk_fall and frame_start stay 0 whatever the bit clock and strobe do.
- R9: frame_delay is 0 on entry to asynchronous mode. It rises one clock after the first frame_start pulse and stays high while async_mode = 1. It returns to 0 one clock after async_mode falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock: bit clock in synchronous modes, 4.096 MHz master clock in asynchronous modes |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_sel | input | 3 | Clock-speed select code |
| bclk_in | input | 1 | External bit clock (asynchronous to clk in asynchronous modes) |
| stb_in | input | 1 | External frame strobe, active high |
| tick_512k | output | 1 | 512 kHz codec timing enable pulse |
| async_mode | output | 1 | 1 when an asynchronous mode is selected |
| sel_err | output | 1 | 1 when the select code is unused |
| bclk_rise | output | 1 | Resynchronized bit-clock rising-edge strobe |
| bclk_fall | output | 1 | Resynchronized bit-clock falling-edge strobe |
| frame_start | output | 1 | Resynchronized strobe rising-edge pulse |
| frame_delay | output | 1 | One-frame pipeline delay control |

## Verification
On every cycle, the assertions check these properties: an unused code produces no enable, enable pulses stay single-cycle at ratios above 1, the two edge outputs are never both high, a strobe fall never gives a frame start, and the edge outputs stay quiet in synchronous modes. They also check that frame_delay only rises right after a frame start and clears once asynchronous mode ends. The divide ratio for each code, the mode flag for each code, and the exact two-clock latency from an input transition to its edge strobe can only be shown by the bench. It measures these over stretches of clocks for every select code.

// File: rtl/pcm_clkmode_pkg.sv
package pcm_clkmode_pkg;

    localparam int SEL_W    = 3;
    localparam int DIV_W    = 4;
    localparam int BASE_KHZ = 512;
    localparam int MCLK_KHZ = 4096;

    typedef struct packed {
        logic             valid;
        logic             async;
        logic [DIV_W-1:0] ratio;
    } mode_t;

    // Block-clock rate for each code, from which the divide ratio follows.
    function automatic mode_t decode_sel(input logic [SEL_W-1:0] code);
        mode_t m;
        int    khz;
        m     = '0;
        khz   = 0;
        case (code)
            3'b000:  khz = 512;
            3'b001:  khz = 1536;
            3'b010:  khz = 2048;
            3'b011:  khz = 4096;
            3'b100,
            3'b101:  khz = MCLK_KHZ;
            default: khz = 0;
        endcase
        m.valid = (khz != 0);
        m.async = (code == 3'b100) || (code == 3'b101);
        m.ratio = DIV_W'(khz / BASE_KHZ);
        return m;
    endfunction

endpackage

// File: rtl/pcm_sel_decode.sv
module pcm_sel_decode
    import pcm_clkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] speed_sel,
    output logic             valid,
    output logic             async_mode,
    output logic             sel_err,
    output logic [DIV_W-1:0] ratio
);
    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = decode_sel(speed_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign valid      = mode_q.valid;
    assign async_mode = mode_q.async;
    assign sel_err    = !mode_q.valid && rst_n;
    assign ratio      = mode_q.ratio;

    // R4: an error code never reports an asynchronous mode
    a_r4_err_not_async: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> !async_mode);
    // R3: every asynchronous mode divides by eight
    a_r3_async_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        async_mode |-> (ratio == DIV_W'(MCLK_KHZ / BASE_KHZ)));
endmodule

// File: rtl/pcm_tick_div.sv
module pcm_tick_div
    import pcm_clkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
        logic             tick;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!valid || (ratio != div_q.ratio)) begin
            div_d.cnt   = '0;
            div_d.tick  = 1'b0;
            div_d.ratio = ratio;
        end else begin
            div_d.tick = (div_q.cnt == ratio - DIV_W'(1));
            div_d.cnt  = div_d.tick ? '0 : div_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = div_q.tick;

    // R4: no enable after an unused code was seen
    a_r4_no_tick_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !tick);
    // R5: single-cycle pulses whenever the ratio exceeds one
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio != DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = enable &&  sh_q[LAST-1] && !sh_q[LAST];
    assign fall = enable && !sh_q[LAST-1] &&  sh_q[LAST];

    // R6: rising and falling strobes are exclusive and last one cycle
    a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
    a_r6_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pcm_clkmode_ctrl.sv
module pcm_clkmode_ctrl
    import pcm_clkmode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] speed_sel,
    input  logic             bclk_in,
    input  logic             stb_in,
    output logic             tick_512k,
    output logic             async_mode,
    output logic             sel_err,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             frame_start,
    output logic             frame_delay
);
    localparam int N_IN = 2;

    logic             mode_valid;
    logic [DIV_W-1:0] mode_ratio;
    logic [N_IN-1:0]  sync_in, sync_rise, sync_fall;
    logic             stb_fall;
    logic             delay_d, delay_q;

    pcm_sel_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_sel  (speed_sel),
        .valid      (mode_valid),
        .async_mode (async_mode),
        .sel_err    (sel_err),
        .ratio      (mode_ratio)
    );

    pcm_tick_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (mode_valid),
        .ratio (mode_ratio),
        .tick  (tick_512k)
    );

    assign sync_in = {stb_in, bclk_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (async_mode),
            .din    (sync_in[g]),
            .rise   (sync_rise[g]),
            .fall   (sync_fall[g])
        );
    end

    assign bclk_rise   = sync_rise[0];
    assign bclk_fall   = sync_fall[0];
    assign frame_start = sync_rise[1];
    assign stb_fall    = sync_fall[1];

    always_comb begin
        delay_d = async_mode ? (delay_q || frame_start) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) delay_q <= 1'b0;
        else        delay_q <= delay_d;
    end

    assign frame_delay = delay_q;

    // R7: a strobe fall never starts a frame
    a_r7_fall_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fall |-> !frame_start);
    // R8: edge outputs quiet outside asynchronous modes
    a_r8_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode |-> !(bclk_rise || bclk_fall || frame_start));
    // R9: delay control engages only right after a frame start
    a_r9_delay_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_delay) |-> $past(frame_start));
    // R9: delay control clears once asynchronous mode is left
    a_r9_delay_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode |=> !frame_delay);
endmodule

// File: tb/tb_pcm_clkmode_ctrl.sv
module tb_pcm_clkmode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] speed_sel = 3'b000;
    logic       bclk_in = 1'b0;
    logic       stb_in = 1'b0;
    logic tick_512k, async_mode, sel_err, bclk_rise, bclk_fall, frame_start, frame_delay;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_clkmode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .bclk_in(bclk_in),
        .stb_in(stb_in), .tick_512k(tick_512k), .async_mode(async_mode),
        .sel_err(sel_err), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .frame_start(frame_start), .frame_delay(frame_delay)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 tick in reset", tick_512k, 0);
        chk("R1 outputs in reset",
            {async_mode, sel_err, bclk_rise, bclk_fall, frame_start, frame_delay}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset",
            {tick_512k, async_mode, sel_err, bclk_rise, bclk_fall, frame_start, frame_delay}, 0);
    endtask

    task automatic t_ratio(input logic [2:0] code, input int period,
                           input int exp_async, input string tag);
        int cnt = 0;
        int last = -1;
        int bad_gap = 0;
        @(negedge clk);
        speed_sel = code;
        @(negedge clk);
        chk({tag, " mode flag"}, async_mode, exp_async);
        chk({tag, " no error"}, sel_err, 0);
        idle(20);
        for (int i = 0; i < WINDOW; i++) begin
            @(negedge clk);
            if (tick_512k) begin
                if (last >= 0 && (i - last) != period) bad_gap++;
                last = i;
                cnt++;
            end
        end
        chk({tag, " tick count"}, cnt, WINDOW / period);
        chk({tag, " R5 tick spacing errors"}, bad_gap, 0);
    endtask

    task automatic t_invalid(input logic [2:0] code);
        int cnt = 0;
        @(negedge clk);
        speed_sel = code;
        @(negedge clk);
        chk("R4 sel_err", sel_err, 1);
        chk("R4 async_mode", async_mode, 0);
        for (int i = 0; i < WINDOW; i++) begin
            @(negedge clk);
            if (tick_512k) cnt++;
        end
        chk("R4 ticks on unused code", cnt, 0);
    endtask

    task automatic t_bclk_edges;
        @(negedge clk);
        speed_sel = 3'b101;
        idle(4);
        bclk_in = 1'b1;
        @(negedge clk);
        chk("R6 rise before latency", bclk_rise, 0);
        @(negedge clk);
        chk("R6 rise pulse", bclk_rise, 1);
        chk("R6 no fall on rise", bclk_fall, 0);
        @(negedge clk);
        chk("R6 rise one cycle", bclk_rise, 0);
        idle(3);
        bclk_in = 1'b0;
        @(negedge clk);
        chk("R6 fall before latency", bclk_fall, 0);
        @(negedge clk);
        chk("R6 fall pulse", bclk_fall, 1);
        chk("R6 no rise on fall", bclk_rise, 0);
        @(negedge clk);
        chk("R6 fall one cycle", bclk_fall, 0);
    endtask

    task automatic t_frame_delay;
        int starts = 0;
        @(negedge clk);
        speed_sel = 3'b000;
        idle(4);
        speed_sel = 3'b100;
        idle(4);
        chk("R9 delay off on entry", frame_delay, 0);
        stb_in = 1'b1;
        @(negedge clk);
        chk("R7 start before latency", frame_start, 0);
        @(negedge clk);
        chk("R7 frame_start pulse", frame_start, 1);
        chk("R9 delay not yet", frame_delay, 0);
        @(negedge clk);
        chk("R7 start one cycle", frame_start, 0);
        chk("R9 delay engaged", frame_delay, 1);
        idle(2);
        stb_in = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (frame_start) starts++;
        end
        chk("R7 no start on strobe fall", starts, 0);
        chk("R9 delay held", frame_delay, 1);
        speed_sel = 3'b000;
        @(negedge clk);
        chk("R2 back to sync", async_mode, 0);
        @(negedge clk);
        chk("R9 delay cleared", frame_delay, 0);
    endtask

    task automatic t_sync_quiet;
        int hits = 0;
        @(negedge clk);
        speed_sel = 3'b011;
        idle(3);
        for (int i = 0; i < 6; i++) begin
            bclk_in = ~bclk_in;
            stb_in  = ~stb_in;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                if (bclk_rise || bclk_fall || frame_start) hits++;
            end
        end
        chk("R8 edge outputs in sync mode", hits, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(2);
        t_reset();
        t_ratio(3'b000, 1, 0, "R2 code000");
        t_ratio(3'b001, 3, 0, "R2 code001");
        t_ratio(3'b010, 4, 0, "R2 code010");
        t_ratio(3'b011, 8, 0, "R2 code011");
        t_ratio(3'b100, 8, 1, "R3 code100");
        t_ratio(3'b101, 8, 1, "R3 code101");
        t_invalid(3'b110);
        t_invalid(3'b111);
        t_ratio(3'b001, 3, 0, "R2 recover001");
        t_bclk_edges();
        t_frame_delay();
        t_sync_quiet();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule